// File: doc/BRIEF.md
# Divider Control and Update Sequencer

This block is the control side of a real-time clock's timebase. A countdown chain divides an incoming timebase tick down to one update per second. A 3-bit divider control field decides whether that chain runs, stands still or is held at its reset point. Releasing the chain from its reset point places the first update exactly half a second later. After that, updates follow once every second.

For each update the block drives a single-cycle enable pulse to the time counters. One cycle later it drives a single-cycle update-ended pulse. The update-in-progress status bit rises a fixed number of ticks before the update, so software that reads it as 0 has a guaranteed window in which to read the time. While the software SET bit is high, no update pulses are issued, but the chain keeps its phase. The block also holds the update-interrupt enable bit, which SET or a reset forces to 0.

Top module: `rtc_update_seq`

## Requirements
- R1: The divider field `div_sel` selects the chain mode. 3'b010 runs the chain, and each tick decrements the ticks-remaining count. Any value with bits [2:1] = 2'b11 holds the chain in reset and reloads the count to half a second (TICKS_PER_SEC/2) on every clock. Every other value stops the chain: the count is held and no updates are produced.
- R2: After the field changes from a reset pattern to 3'b010, the first `upd_en` pulse follows the TICKS_PER_SEC/2-th tick.
- R3: While running with SET low, exactly one `upd_en` pulse occurs every TICKS_PER_SEC ticks. The pulse appears in the clock cycle after the tick that brings the remaining count from 1 to a reload of TICKS_PER_SEC.
- R4: `uip` is 1 while the chain runs with SET low and at most UIP_LEAD_TICKS ticks remain, and also during the `upd_en` cycle. In every other case it is 0, so it falls in the cycle in which `upd_done` is 1.
- R5: `upd_done` is a one-cycle pulse in the clock cycle directly after each `upd_en` pulse.
- R6: While `set_hold` is 1, no `upd_en` is produced, even when the count expires. The chain keeps counting and reloading, and `uip` is 0.
- R7: `uie` is cleared by reset and in any cycle after `set_hold` is 1. A write (`uie_wr`) with `set_hold` low loads `uie_wdata`. A write during SET is ignored.
- R8: After reset, `uip`, `upd_en`, `upd_done` and `uie` are 0, and the chain is at half a second to the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase tick |
| div_sel | input | 3 | Divider control field |
| set_hold | input | 1 | SET bit: blocks updates |
| uie_wr | input | 1 | Write strobe for the update-interrupt enable |
| uie_wdata | input | 1 | Value written to the update-interrupt enable |
| uip | output | 1 | Update-in-progress status |
| upd_en | output | 1 | Update-enable pulse to the time counters |
| upd_done | output | 1 | Update-ended pulse |
| uie | output | 1 | Update-interrupt enable bit |

## Verification
A vector table steps the divider field through the run, stop and both reset patterns, and counts update pulses and samples `uip` after each burst of ticks. Running stretches placed just above and just below the warning threshold separate a correct lead from an off-by-one lead. A stop pattern applied inside the warning window shows that `uip` follows the run state and not the count alone. Returning from a reset pattern and counting exactly half a period separates a half-second reload from a full one, and a full period with SET high shows that updates are suppressed while the phase is kept. Directed tests then check the cycle-exact order of `upd_en`, `upd_done` and the fall of `uip`, along with the enable bit's clear and write rules.

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int TICKS_PER_SEC  = 16,
  parameter int UIP_LEAD_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] div_sel,
  input  logic       set_hold,
  input  logic       uie_wr,
  input  logic       uie_wdata,
  output logic       uip,
  output logic       upd_en,
  output logic       upd_done,
  output logic       uie
);

  localparam int CW = $clog2(TICKS_PER_SEC + 1);
  localparam logic [CW-1:0] FULL = CW'(TICKS_PER_SEC);
  localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] LEAD = CW'(UIP_LEAD_TICKS);

  logic [CW-1:0] remain;
  logic          run_mode, rst_mode, expire;

  assign run_mode = (div_sel == 3'b010);
  assign rst_mode = (div_sel[2:1] == 2'b11);
  assign expire   = run_mode && tick && (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        remain <= HALF;
    else if (rst_mode) remain <= HALF;
    else if (run_mode && tick) remain <= expire ? FULL : remain - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_en   <= 1'b0;
      upd_done <= 1'b0;
    end else begin
      upd_en   <= expire && !set_hold;
      upd_done <= upd_en;
    end
  end

  assign uip = (run_mode && !set_hold && remain <= LEAD) || upd_en;

  always_ff @(posedge clk) begin
    if (!rst_n || set_hold) uie <= 1'b0;
    else if (uie_wr)        uie <= uie_wdata;
  end

  AST_UPD_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> $past(div_sel == 3'b010 && !set_hold && tick)); // R3
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> upd_done); // R5
  AST_DONE_ONLY_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(upd_en)); // R5
  AST_UIP_WARNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_en) |-> $past(uip)); // R4
  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel[2:1] == 2'b11) |=> !upd_en); // R1
  AST_SET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> !upd_en); // R6
  AST_SET_CLEARS_UIE: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> !uie); // R7
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> !upd_en); // R3

endmodule

// File: tb/rtc_update_seq_tb.sv
module rtc_update_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, set_hold = 1'b0;
  logic uie_wr = 1'b0, uie_wdata = 1'b0;
  logic [2:0] div_sel = 3'b010;
  logic uip, upd_en, upd_done, uie;
  int checks = 0, fails = 0, n_upd = 0;

  always #5 clk = ~clk;

  rtc_update_seq #(.TICKS_PER_SEC(16), .UIP_LEAD_TICKS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_sel(div_sel),
    .set_hold(set_hold), .uie_wr(uie_wr), .uie_wdata(uie_wdata),
    .uip(uip), .upd_en(upd_en), .upd_done(upd_done), .uie(uie));

  always @(posedge clk) if (upd_en) n_upd <= n_upd + 1;

  localparam int NV = 16;
  localparam logic [2:0] V_DIV [NV] = '{3'b011, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010,
    3'b110, 3'b010, 3'b010, 3'b111, 3'b000, 3'b010, 3'b010, 3'b101, 3'b010, 3'b010};
  localparam logic V_SET [NV] = '{0,0,0,0,0,1,0,0,0,0,0,0,0,0,0,0};
  localparam int V_TICKS [NV] = '{5,4,1,3,16,16,3,7,1,2,20,8,14,0,0,2};
  localparam int V_UPD [NV]   = '{0,0,0,1,1,0,0,0,1,0,0,1,0,0,0,1};
  localparam logic V_UIP [NV] = '{0,0,1,0,0,0,0,1,0,0,0,0,1,0,1,0};
  localparam string V_REQ [NV] = '{"R1","R1","R4","R3","R3","R6","R1","R4",
    "R2","R1","R1","R2","R4","R4","R4","R3"};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 uip", uip, 0);
    check("R8 upd_en", upd_en, 0);
    check("R8 upd_done", upd_done, 0);
    check("R8 uie", uie, 0);

    for (int v = 0; v < NV; v++) begin
      int base;
      @(negedge clk);
      div_sel = V_DIV[v];
      set_hold = V_SET[v];
      base = n_upd;
      do_ticks(V_TICKS[v]);
      repeat (3) @(negedge clk);
      check(V_REQ[v], n_upd - base, V_UPD[v]);
      check(V_REQ[v], uip, V_UIP[v]);
    end

    // R3 R4 R5 cycle-exact update order; remain is 16 here
    set_hold = 1'b0;
    div_sel = 3'b010;
    do_ticks(15);
    @(negedge clk);
    check("R4 uip before update", uip, 1);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R3 upd_en", upd_en, 1);
    check("R4 uip during update", uip, 1);
    check("R5 done not early", upd_done, 0);
    @(negedge clk);
    check("R5 upd_done", upd_done, 1);
    check("R5 upd_en single", upd_en, 0);
    check("R4 uip falls", uip, 0);
    @(negedge clk);
    check("R5 done single", upd_done, 0);

    // R7 enable bit rules
    uie_wr = 1'b1; uie_wdata = 1'b1;
    @(negedge clk) uie_wr = 1'b0;
    check("R7 uie write", uie, 1);
    set_hold = 1'b1;
    @(negedge clk);
    check("R7 set clears uie", uie, 0);
    uie_wr = 1'b1;
    @(negedge clk) uie_wr = 1'b0;
    check("R7 write ignored during set", uie, 0);
    set_hold = 1'b0;
    uie_wr = 1'b1;
    @(negedge clk) uie_wr = 1'b0;
    check("R7 uie rewrite", uie, 1);
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check("R7 reset clears uie", uie, 0);

    // R8 reset reloads half period: 8 ticks give an update
    begin
      int base;
      base = n_upd;
      do_ticks(7);
      repeat (3) @(negedge clk);
      check("R8 no update before half", n_upd - base, 0);
      do_ticks(1);
      repeat (3) @(negedge clk);
      check("R8 update at half", n_upd - base, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule